// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block turns an unsigned phase word into a full-scale two's-complement sine sample. It does this by rotating a vector through an unrolled chain of CORDIC shift-and-add stages. A new phase is accepted on every clock. A fixed number of cycles later the rotated vector appears on two outputs: the sine, which is the result used downstream, and the cosine, which comes free from the same rotation and can serve as the quadrature partner.

The top two phase bits pick the quadrant. Phases in the second and third quadrants are moved by half a turn into the -90..+90 degree range, and the signs of both results are flipped again at the end. The rotation starts from a vector whose length is full scale divided by the CORDIC gain of the chosen stage count. The result therefore always has unity amplitude, whatever the datapath, stage and phase widths.

The iteration count (`STAGES`), the CORDIC datapath width (`DATA_W`, with a few internal guard bits) and the output width (`OUT_W`, at most `DATA_W`) are set independently. The per-stage angle constants and the start-vector length are computed when the design is elaborated. A result of exactly +1.0 is clamped to the largest positive code so that it does not wrap. Amplitude scaling, tone summation and phase accumulation are done outside this block.

Top module: `cordic_sin_gen`

## Requirements
- R1: While `rst` is high, and after its release until the first phase sampled after reset reaches the outputs, both `sin_out` and `cos_out` read 0.
- R2: For phase p the angle is 2*pi*p/2^PHASE_W. The code 2^(OUT_W-1) stands for +1.0. `sin_out` is within 3 codes of the rounded ideal sine, with the ideal value clamped at 2^(OUT_W-1)-1, for every phase.
- R3: `cos_out` meets the same 3-code bound against the rounded and clamped ideal cosine for every phase.
- R4: A phase sampled at rising edge n is reflected on both outputs from just after edge n+STAGES+1, which is STAGES+2 register stages. A new phase is taken every cycle and the results leave in input order.
- R5: Positive full scale never wraps. The sine at phase 2^(PHASE_W-2) and the cosine at phase 0 come out within 3 codes below 2^(OUT_W-1)-1 and never at the most negative code.
- R6: The quadrant is given by phase bits [PHASE_W-1:PHASE_W-2]. The sine is above -4 for quadrants 00 and 01 and below +4 for quadrants 10 and 11. The cosine is above -4 for quadrants 00 and 11 and below +4 for quadrants 01 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | PHASE_W | Unsigned phase, one full turn = 2^PHASE_W |
| sin_out | output | OUT_W | Signed sine sample, +1.0 = 2^(OUT_W-1) clamped |
| cos_out | output | OUT_W | Signed cosine sample, same scale |

## Verification
The bench streams every phase of the default configuration through the pipeline back to back. It then streams a scrambled stride sequence, so that a stage whose angle constant, shift amount or rotation direction is wrong shows up as a large error at the affected phases instead of hiding in an average. The four quadrant boundaries are the sharpest corners. A fold that chooses the wrong quadrant produces mirror-image samples with the wrong sign, and a missing clamp turns the +1.0 results at 90 degrees (sine) and 0 degrees (cosine) into the most negative code. The pipeline is checked cycle by cycle as it fills after reset. A register added or dropped in the chain would bring the first real cosine one cycle early or late, or let the start vector leak out before any phase arrives.

// File: rtl/cordic_sin_pkg.sv
package cordic_sin_pkg;

    typedef enum logic [1:0] {
        Q_FIRST  = 2'b00,
        Q_SECOND = 2'b01,
        Q_THIRD  = 2'b10,
        Q_FOURTH = 2'b11
    } quad_e;

    localparam real PI_R = 3.14159265358979323846;

    // 2.0 raised to an integer power, built from repeated doubling or halving
    function automatic real pow2_r(input int e);
        real r;
        r = 1.0;
        if (e >= 0) begin
            for (int k = 0; k < e; k++) r = r * 2.0;
        end else begin
            for (int k = 0; k < -e; k++) r = r * 0.5;
        end
        return r;
    endfunction

    // Newton square root for positive arguments
    function automatic real sqrt_r(input real v);
        real g;
        g = (v > 1.0) ? v : 1.0;
        for (int k = 0; k < 64; k++) g = 0.5 * (g + v / g);
        return g;
    endfunction

    // arctangent on [0,1]: three half-angle reductions, then an odd power series
    function automatic real atan_r(input real v);
        real t;
        real t2;
        real term;
        real acc;
        t = v;
        for (int k = 0; k < 3; k++) t = t / (1.0 + sqrt_r(1.0 + t * t));
        t2   = t * t;
        term = t;
        acc  = 0.0;
        for (int k = 0; k < 24; k++) begin
            acc  = acc + term / real'(2 * k + 1);
            term = -term * t2;
        end
        return 8.0 * acc;
    endfunction

    // atan(2^-idx) expressed in angle units where one turn = 2^turn_bits
    function automatic longint angle_code(input int idx, input int turn_bits);
        return longint'(atan_r(pow2_r(-idx)) / (2.0 * PI_R) * pow2_r(turn_bits));
    endfunction

    // start-vector length: 2^one_bits divided by the gain of `stages` rotations
    function automatic longint start_code(input int stages, input int one_bits);
        real gain;
        gain = 1.0;
        for (int k = 0; k < stages; k++) gain = gain * sqrt_r(1.0 + pow2_r(-2 * k));
        return longint'(pow2_r(one_bits) / gain);
    endfunction

endpackage

// File: rtl/cordic_sin_fold.sv
module cordic_sin_fold
    import cordic_sin_pkg::*;
#(
    parameter int     PHASE_W     = 16,
    parameter int     ANGLE_GUARD = 6,
    parameter int     IW          = 22,
    parameter longint X_START     = 0
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [PHASE_W-1:0]                     phase_in,
    output logic signed [IW-1:0]                   x_q,
    output logic signed [PHASE_W+ANGLE_GUARD-1:0]  z_q,
    output quad_e                                  quad_q
);
    localparam int     ZW      = PHASE_W + ANGLE_GUARD;
    localparam longint QUARTER = longint'(1) << (ZW - 2);

    logic               flip;
    logic [PHASE_W-1:0] folded;

    // quadrants 01 and 10 move by half a turn: invert the top bit
    always_comb begin
        flip                = phase_in[PHASE_W-1] ^ phase_in[PHASE_W-2];
        folded              = phase_in;
        folded[PHASE_W-1]   = phase_in[PHASE_W-1] ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            z_q    <= '0;
            quad_q <= Q_FIRST;
        end else begin
            x_q    <= X_START[IW-1:0];
            z_q    <= {folded, {ANGLE_GUARD{1'b0}}};
            quad_q <= quad_e'(phase_in[PHASE_W-1 -: 2]);
        end
    end

    // R6: the folded angle handed to the rotation lies in [-90, +90) degrees
    p_fold_range_r6: assert property (@(posedge clk) disable iff (rst)
        (longint'(z_q) >= -QUARTER) && (longint'(z_q) < QUARTER));

endmodule

// File: rtl/cordic_sin_stage.sv
module cordic_sin_stage
    import cordic_sin_pkg::*;
#(
    parameter int IDX = 0,
    parameter int IW  = 22,
    parameter int ZW  = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [IW-1:0] x_in,
    input  logic signed [IW-1:0] y_in,
    input  logic signed [ZW-1:0] z_in,
    input  quad_e                quad_in,
    output logic signed [IW-1:0] x_q,
    output logic signed [IW-1:0] y_q,
    output logic signed [ZW-1:0] z_q,
    output quad_e                quad_q
);
    localparam longint              ANG_L = angle_code(IDX, ZW);
    localparam logic signed [ZW-1:0] ANG  = ANG_L[ZW-1:0];

    logic signed [IW-1:0] x_sh, y_sh, x_nx, y_nx;
    logic signed [ZW-1:0] z_nx;

    always_comb begin
        x_sh = x_in >>> IDX;
        y_sh = y_in >>> IDX;
        if (z_in[ZW-1]) begin
            x_nx = x_in + y_sh;
            y_nx = y_in - x_sh;
            z_nx = z_in + ANG;
        end else begin
            x_nx = x_in - y_sh;
            y_nx = y_in + x_sh;
            z_nx = z_in - ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            quad_q <= Q_FIRST;
        end else begin
            x_q    <= x_nx;
            y_q    <= y_nx;
            z_q    <= z_nx;
            quad_q <= quad_in;
        end
    end

    function automatic longint mag(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // R2: each micro-rotation never grows the residual past max(|residual|, stage angle)
    p_residual_bound_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mag(longint'(z_q)) <=
                 ((mag(longint'($past(z_in))) > ANG_L) ? mag(longint'($past(z_in))) : ANG_L));

endmodule

// File: rtl/cordic_sin_out.sv
module cordic_sin_out
    import cordic_sin_pkg::*;
#(
    parameter int IW       = 22,
    parameter int ONE_SH   = 20,
    parameter int OUT_W    = 16,
    parameter int SIGN_TOL = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IW-1:0]    x_in,
    input  logic signed [IW-1:0]    y_in,
    input  quad_e                   quad_in,
    output logic signed [OUT_W-1:0] sin_q,
    output logic signed [OUT_W-1:0] cos_q
);
    localparam int     SH   = ONE_SH - (OUT_W - 1);
    localparam longint HALF = longint'(1) << (SH - 1);
    localparam longint MAXP = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint MINN = -(longint'(1) << (OUT_W - 1));
    localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    // undo the fold, round to the output grid and clamp
    function automatic logic signed [OUT_W-1:0] to_code(input logic signed [IW-1:0] v,
                                                        input logic neg);
        longint w;
        longint r;
        w = longint'(v);
        if (neg) w = -w;
        r = (w + HALF) >>> SH;
        if (r > MAXP)      r = MAXP;
        else if (r < MINN) r = MINN;
        return r[OUT_W-1:0];
    endfunction

    logic flip, s_up, c_up;

    always_comb begin
        flip = (quad_in == Q_SECOND) || (quad_in == Q_THIRD);
        s_up = (quad_in == Q_FIRST)  || (quad_in == Q_SECOND);
        c_up = (quad_in == Q_FIRST)  || (quad_in == Q_FOURTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            sin_q <= to_code(y_in, flip);
            cos_q <= to_code(x_in, flip);
        end
    end

    // R6: result signs follow the quadrant carried alongside the rotation
    p_sin_sign_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(s_up) ? (int'(sin_q) > -SIGN_TOL) : (int'(sin_q) < SIGN_TOL)));
    p_cos_sign_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(c_up) ? (int'(cos_q) > -SIGN_TOL) : (int'(cos_q) < SIGN_TOL)));

    // R5: a positive full-scale result never wraps to the most negative code
    p_no_wrap_sin_r5: assert property (@(posedge clk) disable iff (rst)
        s_up |=> sin_q != MIN_CODE);
    p_no_wrap_cos_r5: assert property (@(posedge clk) disable iff (rst)
        c_up |=> cos_q != MIN_CODE);

endmodule

// File: rtl/cordic_sin_gen.sv
module cordic_sin_gen
    import cordic_sin_pkg::*;
#(
    parameter int PHASE_W     = 16,
    parameter int DATA_W      = 16,
    parameter int STAGES      = 16,
    parameter int OUT_W       = 16,
    parameter int ANGLE_GUARD = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PHASE_W-1:0]      phase_in,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);
    // guard bits below the datapath LSB absorb shift truncation over the chain
    localparam int     GUARD_XY = $clog2(STAGES) + 1;
    localparam int     IW       = DATA_W + GUARD_XY + 1;
    localparam int     ONE_SH   = DATA_W - 1 + GUARD_XY;
    localparam int     ZW       = PHASE_W + ANGLE_GUARD;
    localparam longint X_START  = start_code(STAGES, ONE_SH);

    logic signed [IW-1:0] x_s [STAGES+1];
    logic signed [IW-1:0] y_s [STAGES+1];
    logic signed [ZW-1:0] z_s [STAGES+1];
    quad_e                q_s [STAGES+1];

    assign y_s[0] = '0;

    cordic_sin_fold #(
        .PHASE_W     (PHASE_W),
        .ANGLE_GUARD (ANGLE_GUARD),
        .IW          (IW),
        .X_START     (X_START)
    ) u_fold (
        .clk      (clk),
        .rst      (rst),
        .phase_in (phase_in),
        .x_q      (x_s[0]),
        .z_q      (z_s[0]),
        .quad_q   (q_s[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_rot
        cordic_sin_stage #(
            .IDX (g),
            .IW  (IW),
            .ZW  (ZW)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .x_in    (x_s[g]),
            .y_in    (y_s[g]),
            .z_in    (z_s[g]),
            .quad_in (q_s[g]),
            .x_q     (x_s[g+1]),
            .y_q     (y_s[g+1]),
            .z_q     (z_s[g+1]),
            .quad_q  (q_s[g+1])
        );
    end

    cordic_sin_out #(
        .IW       (IW),
        .ONE_SH   (ONE_SH),
        .OUT_W    (OUT_W),
        .SIGN_TOL (4)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .x_in    (x_s[STAGES]),
        .y_in    (y_s[STAGES]),
        .quad_in (q_s[STAGES]),
        .sin_q   (sin_out),
        .cos_q   (cos_out)
    );

    // the residual angle is consumed by the last stage only through its sign chain
    logic unused_z;
    assign unused_z = ^z_s[STAGES];

endmodule

// File: tb/cordic_sin_gen_tb.sv
`timescale 1ns/1ps
module cordic_sin_gen_tb;
    localparam int  PW   = 16;
    localparam int  DW   = 16;
    localparam int  ST   = 16;
    localparam int  OW   = 16;
    localparam int  LAT  = ST + 2;
    localparam int  TOL  = 3;
    localparam int  MAXP = (1 << (OW - 1)) - 1;
    localparam int  MINC = -(1 << (OW - 1));
    localparam int  MASK = (1 << PW) - 1;
    localparam real PI_R = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [PW-1:0]        phase = '0;
    logic signed [OW-1:0] sin_o;
    logic signed [OW-1:0] cos_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int hist [256];

    cordic_sin_gen #(
        .PHASE_W     (PW),
        .DATA_W      (DW),
        .STAGES      (ST),
        .OUT_W       (OW),
        .ANGLE_GUARD (6)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .phase_in (phase),
        .sin_out  (sin_o),
        .cos_out  (cos_o)
    );

    always #2 clk = ~clk;

    task automatic check_near(input string req, input string what, input int p,
                              input int act, input int exp, input int tol);
        total++;
        if (act > exp + tol || act < exp - tol) begin
            bad++;
            $display("FAIL %s %s phase=%0d actual=%0d expected=%0d tol=%0d",
                     req, what, p, act, exp, tol);
        end
    endtask

    task automatic check_cond(input string req, input string what, input int p,
                              input bit ok, input int act, input int bound);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s phase=%0d actual=%0d expected_bound=%0d",
                     req, what, p, act, bound);
        end
    endtask

    function automatic int ref_val(input int p, input bit want_cos);
        real ang;
        real v;
        int  r;
        ang = 2.0 * PI_R * real'(p) / real'(1 << PW);
        v   = (want_cos ? $cos(ang) : $sin(ang)) * real'(1 << (OW - 1));
        r   = $rtoi((v >= 0.0) ? v + 0.5 : v - 0.5);
        if (r > MAXP) r = MAXP;
        return r;
    endfunction

    task automatic check_sample(input int p);
        int  s, c, q;
        bit  s_up, c_up;
        s = int'(sin_o);
        c = int'(cos_o);
        q = p >> (PW - 2);
        s_up = (q == 0) || (q == 1);
        c_up = (q == 0) || (q == 3);
        check_near("R2", "sine", p, s, ref_val(p, 1'b0), TOL);
        check_near("R3", "cosine", p, c, ref_val(p, 1'b1), TOL);
        check_cond("R6", "sine sign", p, s_up ? (s > -4) : (s < 4), s, s_up ? -4 : 4);
        check_cond("R6", "cosine sign", p, c_up ? (c > -4) : (c < 4), c, c_up ? -4 : 4);
        if (p == (1 << (PW - 2))) begin
            check_near("R5", "sine at quarter turn", p, s, MAXP, TOL);
            check_cond("R5", "sine no wrap", p, s != MINC, s, MAXP);
        end
        if (p == 0) begin
            check_near("R5", "cosine at zero", p, c, MAXP, TOL);
            check_cond("R5", "cosine no wrap", p, c != MINC, c, MAXP);
        end
    endtask

    // drive one phase per cycle; the result for iteration j is read LAT iterations later
    task automatic stream(input int count, input int start, input int stride, input bit fill_probe);
        for (int j = 0; j < count + LAT; j++) begin
            if (j >= LAT) begin
                check_sample(hist[(j - LAT) % 256]);
                if (fill_probe && j == LAT)
                    check_near("R4", "first cosine on time", 0, int'(cos_o), MAXP, TOL);
            end else if (fill_probe) begin
                if (j == LAT - 1) begin
                    check_near("R4", "cosine one cycle early", -1, int'(cos_o), 0, 0);
                    check_near("R4", "sine one cycle early", -1, int'(sin_o), 0, 0);
                end else begin
                    check_near("R1", "cosine while filling", -1, int'(cos_o), 0, 0);
                    check_near("R1", "sine while filling", -1, int'(sin_o), 0, 0);
                end
            end
            if (j < count) begin
                int pn;
                pn = (start + j * stride) & MASK;
                phase = pn[PW-1:0];
                hist[j % 256] = pn;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        rst   = 1'b1;
        phase = '0;
        repeat (5) @(negedge clk);
        check_near("R1", "sine in reset", -1, int'(sin_o), 0, 0);
        check_near("R1", "cosine in reset", -1, int'(cos_o), 0, 0);
        rst = 1'b0;
        // every phase in order, starting right at reset release
        stream(1 << PW, 0, 1, 1'b1);
        // scrambled order: odd stride visits far-apart phases back to back
        stream(4096, 12345, 40503, 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule